// File: doc/BRIEF.md
# DMA Transfer Classification Monitor

This block watches the side-band signals that come with each word a DMA engine moves for a cell segmentation and reassembly controller. From them it produces five status strobes that an external observer, such as a logic analyser or a debug capture unit, can use to sort the bus traffic. The five strobes are: payload traffic, end-of-unit word, first-cell word, transmit backlog at or below a threshold, and traffic for a watched virtual channel.

There are two timing references. The payload and watched-channel strobes are captured when the active-low attention strobe that opens a transfer falls, and they hold until the next such fall. The end-of-unit and first-cell strobes are set for each data word and are re-evaluated only on word strobes. The backlog strobe is a registered unsigned comparison that is re-evaluated every clock. Each strobe has its own output-enable, which models a three-state pad. All the enables follow one global monitor-enable input.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the registers leave reset two clocks after `rst_n` rises. Every strobe register reads 0 while reset is active.

Top module: `xfer_class_mon`

## Requirements
- R1: All five output-enables (`pay_oe`, `last_oe`, `first_oe`, `low_oe`, `vcsel_oe`) equal `mon_en` in the same cycle: 1 drives the pads, 0 leaves them undriven.
- R2: On the clock where `attn_n` is sampled 0 after having been sampled 1, `pay_o` loads `aal5_pay`. The new value is visible after that edge.
- R3: Between falls of `attn_n`, `pay_o` and `vcsel_o` hold their value. Changes on `aal5_pay` or `vc_mon_bit` have no effect, whatever `attn_n` does otherwise.
- R4: After a word strobe (`word_vld`=1) with `aal5_pay`, `cell_last` and `pkt_last` all 1, `last_o` is 1.
- R5: After a word strobe with `dir_rx`=1 (1 = receive, 0 = transmit) and `rxbuf_last`=1, `last_o` is 1. This holds even when no other flag is set.
- R6: After a receive word strobe with `seg_err`, `cell_last` and `pkt_last` all 1, `last_o` is 1 even when `aal5_pay`=0. With `dir_rx`=0 and `aal5_pay`=0, that combination gives 0.
- R7: `first_o` is 1 after a word strobe only when `dir_rx`, `aal5_pay`, `pkt_first` and `cell_last` are all 1. A transmit word never sets it.
- R8: `last_o` and `first_o` change only on word strobes. They hold through idle cycles and return to 0 on the next word strobe that does not meet their condition.
- R9: One clock after `tx_cells_left` and `cells_thresh` are presented, `low_o` is 1 exactly when `tx_cells_left` <= `cells_thresh` in an unsigned 16-bit compare, equality included.
- R10: On a fall of `attn_n` (as defined in R2), `vcsel_o` loads `vc_mon_bit`.
- R11: While `rst_n` is 0, `pay_o`, `last_o`, `first_o`, `low_o` and `vcsel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Global monitor enable |
| attn_n | input | 1 | Active-low transfer attention strobe |
| word_vld | input | 1 | One data word is transferred this cycle |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| aal5_pay | input | 1 | Transfer carries AAL-5 cell payload |
| cell_last | input | 1 | Word is the last word of its cell |
| pkt_last | input | 1 | Cell is the last cell of its packet |
| pkt_first | input | 1 | Cell is the first cell of its packet |
| rxbuf_last | input | 1 | Word goes to the last location of a receive buffer |
| seg_err | input | 1 | Packet hit the maximum segment count error |
| vc_mon_bit | input | 1 | Monitor bit of the current VC |
| tx_cells_left | input | 16 | Cells remaining in the transmit buffer |
| cells_thresh | input | 16 | Backlog threshold |
| pay_o | output | 1 | Payload traffic strobe |
| pay_oe | output | 1 | Enable for pay_o |
| last_o | output | 1 | End-of-unit word strobe |
| last_oe | output | 1 | Enable for last_o |
| first_o | output | 1 | First-cell word strobe |
| first_oe | output | 1 | Enable for first_o |
| low_o | output | 1 | Transmit backlog at or below threshold |
| low_oe | output | 1 | Enable for low_o |
| vcsel_o | output | 1 | Watched-VC traffic strobe |
| vcsel_oe | output | 1 | Enable for vcsel_o |

## Verification
The hardest case to reach from the ports is a latched value held while its source keeps changing. The source can change while `attn_n` stays low and again after `attn_n` returns high, and neither may reach `pay_o` or `vcsel_o`. The stimulus first forces a clean high-then-low sequence on `attn_n` to load a known value. It then toggles the payload and VC inputs through both attention levels and checks the outputs after each step. In the same way, the word-strobe flags are held on the inputs with `word_vld` low, to show that the pulse outputs move only on real words.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned NUM_OUT = 5;

  typedef enum int unsigned {
    OUT_PAY   = 0,
    OUT_LAST  = 1,
    OUT_FIRST = 2,
    OUT_LOW   = 3,
    OUT_VCSEL = 4
  } xcm_out_e;

  typedef struct packed {
    logic dir_rx;
    logic aal5_pay;
    logic cell_last;
    logic pkt_last;
    logic pkt_first;
    logic rxbuf_last;
    logic seg_err;
  } xcm_word_t;
endpackage

// File: rtl/xcm_rst_sync.sv
module xcm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[TOP];
endmodule

// File: rtl/xcm_edge_latch.sv
module xcm_edge_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         attn_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         attn_q;
  logic         fall;
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  always_comb begin
    fall = attn_q & ~attn_n;
    q_d  = fall ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      attn_q <= 1'b0;
      q_r    <= '0;
    end else begin
      attn_q <= attn_n;
      q_r    <= q_d;
    end
  end

  assign q = q_r;

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_sn)
    (attn_q && !attn_n) |=> (q == $past(d))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !(attn_q && !attn_n) |=> $stable(q)); // R3
endmodule

// File: rtl/xcm_word_flags.sv
module xcm_word_flags
  import xcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      word_vld,
  input  xcm_word_t w,
  output logic      last_o,
  output logic      first_o
);
  logic end_pkt;
  logic end_buf;
  logic end_err;
  logic last_hit;
  logic first_hit;
  logic last_q, last_d;
  logic first_q, first_d;

  always_comb begin
    end_pkt   = w.aal5_pay & w.cell_last & w.pkt_last;
    end_buf   = w.dir_rx & w.rxbuf_last;
    end_err   = w.dir_rx & w.seg_err & w.cell_last & w.pkt_last;
    last_hit  = end_pkt | end_buf | end_err;
    first_hit = w.dir_rx & w.aal5_pay & w.pkt_first & w.cell_last;
    last_d    = word_vld ? last_hit  : last_q;
    first_d   = word_vld ? first_hit : first_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      last_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      last_q  <= last_d;
      first_q <= first_d;
    end
  end

  assign last_o  = last_q;
  assign first_o = first_q;

  AST_FLAGS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !word_vld |=> ($stable(last_q) && $stable(first_q))); // R8
  AST_FIRST_NOT_TX: assert property (@(posedge clk) disable iff (!rst_sn)
    (word_vld && !w.dir_rx) |=> !first_q); // R7
  AST_LAST_RXBUF: assert property (@(posedge clk) disable iff (!rst_sn)
    (word_vld && w.dir_rx && w.rxbuf_last) |=> last_q); // R5
  AST_LAST_PKT_END: assert property (@(posedge clk) disable iff (!rst_sn)
    (word_vld && w.aal5_pay && w.cell_last && w.pkt_last) |=> last_q); // R4
endmodule

// File: rtl/xcm_level_cmp.sv
module xcm_level_cmp #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] thr,
  output logic          low_o
);
  logic low_q;
  logic low_d;

  always_comb begin
    low_d = (cnt <= thr);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) low_q <= 1'b0;
    else         low_q <= low_d;
  end

  assign low_o = low_q;

  AST_LOW_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt == '0) |=> low_q); // R9
  AST_LOW_MAX_CNT: assert property (@(posedge clk) disable iff (!rst_sn)
    ((cnt == '1) && (thr != '1)) |=> !low_q); // R9
endmodule

// File: rtl/xfer_class_mon.sv
module xfer_class_mon
  import xcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             attn_n,
  input  logic             word_vld,
  input  logic             dir_rx,
  input  logic             aal5_pay,
  input  logic             cell_last,
  input  logic             pkt_last,
  input  logic             pkt_first,
  input  logic             rxbuf_last,
  input  logic             seg_err,
  input  logic             vc_mon_bit,
  input  logic [CNT_W-1:0] tx_cells_left,
  input  logic [CNT_W-1:0] cells_thresh,
  output logic             pay_o,
  output logic             pay_oe,
  output logic             last_o,
  output logic             last_oe,
  output logic             first_o,
  output logic             first_oe,
  output logic             low_o,
  output logic             low_oe,
  output logic             vcsel_o,
  output logic             vcsel_oe
);
  localparam int unsigned LATCH_W = 2;

  logic               rst_sn;
  logic [LATCH_W-1:0] latch_d;
  logic [LATCH_W-1:0] latch_q;
  logic [NUM_OUT-1:0] oe_vec;
  xcm_word_t          wflags;

  xcm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    latch_d           = {vc_mon_bit, aal5_pay};
    wflags.dir_rx     = dir_rx;
    wflags.aal5_pay   = aal5_pay;
    wflags.cell_last  = cell_last;
    wflags.pkt_last   = pkt_last;
    wflags.pkt_first  = pkt_first;
    wflags.rxbuf_last = rxbuf_last;
    wflags.seg_err    = seg_err;
  end

  xcm_edge_latch #(.W(LATCH_W)) u_latch (
    .clk    (clk),
    .rst_sn (rst_sn),
    .attn_n (attn_n),
    .d      (latch_d),
    .q      (latch_q)
  );

  xcm_word_flags u_words (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .word_vld (word_vld),
    .w        (wflags),
    .last_o   (last_o),
    .first_o  (first_o)
  );

  xcm_level_cmp #(.CW(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_sn (rst_sn),
    .cnt    (tx_cells_left),
    .thr    (cells_thresh),
    .low_o  (low_o)
  );

  assign pay_o   = latch_q[0];
  assign vcsel_o = latch_q[1];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_oe
    assign oe_vec[g] = mon_en;
  end

  assign pay_oe   = oe_vec[OUT_PAY];
  assign last_oe  = oe_vec[OUT_LAST];
  assign first_oe = oe_vec[OUT_FIRST];
  assign low_oe   = oe_vec[OUT_LOW];
  assign vcsel_oe = oe_vec[OUT_VCSEL];

  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_sn)
    (oe_vec == '0) || (oe_vec == '1)); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(pay_o || last_o || first_o || low_o || vcsel_o)); // R11
endmodule

// File: tb/sim_xfer_class_mon.sv
module sim_xfer_class_mon;
  logic clk = 1'b0;
  logic rst_n, mon_en, attn_n, word_vld, dir_rx, aal5_pay, cell_last, pkt_last;
  logic pkt_first, rxbuf_last, seg_err, vc_mon_bit;
  logic [15:0] tx_cells_left, cells_thresh;
  logic pay_o, pay_oe, last_o, last_oe, first_o, first_oe, low_o, low_oe, vcsel_o, vcsel_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xfer_class_mon u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_word();
    word_vld = 0; dir_rx = 0; aal5_pay = 0; cell_last = 0; pkt_last = 0;
    pkt_first = 0; rxbuf_last = 0; seg_err = 0;
  endtask

  task automatic send_word(input logic rx, input logic pay, input logic cl, input logic pl,
                           input logic pf, input logic rb, input logic se);
    word_vld = 1; dir_rx = rx; aal5_pay = pay; cell_last = cl; pkt_last = pl;
    pkt_first = pf; rxbuf_last = rb; seg_err = se;
    tick();
    clr_word();
  endtask

  task automatic t_reset();
    rst_n = 0; mon_en = 0; attn_n = 1; vc_mon_bit = 0; clr_word();
    tx_cells_left = 0; cells_thresh = 0;
    tick(); tick();
    chk("R11 pay", pay_o, 0);   chk("R11 last", last_o, 0);
    chk("R11 first", first_o, 0); chk("R11 low", low_o, 0);
    chk("R11 vcsel", vcsel_o, 0);
    rst_n = 1;
    repeat (4) tick();
  endtask

  task automatic t_enable();
    mon_en = 0; #1;
    chk("R1 off", pay_oe | last_oe | first_oe | low_oe | vcsel_oe, 0);
    mon_en = 1; #1;
    chk("R1 on", pay_oe & last_oe & first_oe & low_oe & vcsel_oe, 1);
    tick();
  endtask

  task automatic t_attn_latch();
    attn_n = 1; aal5_pay = 0; vc_mon_bit = 0; tick();
    attn_n = 0; aal5_pay = 1; vc_mon_bit = 1; tick();
    chk("R2 pay load", pay_o, 1);
    chk("R10 vc load", vcsel_o, 1);
    aal5_pay = 0; vc_mon_bit = 0; tick();
    chk("R3 pay hold low attn", pay_o, 1);
    chk("R3 vc hold low attn", vcsel_o, 1);
    attn_n = 1; tick();
    chk("R3 pay hold high attn", pay_o, 1);
    chk("R3 vc hold high attn", vcsel_o, 1);
    attn_n = 0; aal5_pay = 0; vc_mon_bit = 1; tick();
    chk("R2 pay second load", pay_o, 0);
    chk("R10 vc second load", vcsel_o, 1);
    attn_n = 1; aal5_pay = 0; vc_mon_bit = 0; tick();
    attn_n = 0; tick();
    chk("R10 vc cleared", vcsel_o, 0);
    attn_n = 1; clr_word(); tick();
  endtask

  task automatic t_last();
    send_word(0, 1, 1, 1, 0, 0, 0);
    chk("R4 tx aal5 end", last_o, 1);
    send_word(0, 1, 1, 0, 0, 0, 0);
    chk("R8 non-last clears", last_o, 0);
    send_word(1, 0, 0, 0, 0, 1, 0);
    chk("R5 rx buffer end", last_o, 1);
    tick();
    chk("R8 idle hold", last_o, 1);
    send_word(0, 0, 0, 0, 0, 1, 0);
    chk("R5 tx buffer flag ignored", last_o, 0);
    send_word(1, 0, 1, 1, 0, 0, 1);
    chk("R6 seg error end", last_o, 1);
    send_word(0, 0, 1, 1, 0, 0, 1);
    chk("R6 tx seg no last", last_o, 0);
    word_vld = 0; aal5_pay = 1; cell_last = 1; pkt_last = 1; tick();
    chk("R8 no strobe no set", last_o, 0);
    clr_word();
  endtask

  task automatic t_first();
    send_word(1, 1, 1, 0, 1, 0, 0);
    chk("R7 rx first cell", first_o, 1);
    tick();
    chk("R8 first idle hold", first_o, 1);
    send_word(1, 1, 0, 0, 1, 0, 0);
    chk("R7 not cell last", first_o, 0);
    send_word(0, 1, 1, 0, 1, 0, 0);
    chk("R7 tx never first", first_o, 0);
  endtask

  task automatic t_low();
    tx_cells_left = 5; cells_thresh = 5; tick();
    chk("R9 equal", low_o, 1);
    tx_cells_left = 6; tick();
    chk("R9 above", low_o, 0);
    cells_thresh = 6; tick();
    chk("R9 threshold write", low_o, 1);
    tx_cells_left = 16'hFFFF; cells_thresh = 16'h0001; tick();
    chk("R9 unsigned high count", low_o, 0);
    tx_cells_left = 16'h8000; cells_thresh = 16'hFFFF; tick();
    chk("R9 unsigned high thresh", low_o, 1);
    tx_cells_left = 0; cells_thresh = 0; tick();
    chk("R9 zero", low_o, 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_attn_latch();
    t_last();
    t_first();
    t_low();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule